// File: doc/BRIEF.md
# DC-Balanced Frame Encoder

This block forms one parallel line frame on every word clock for a serial link. A frame holds a 4-bit control field, a flag bit and a data field that is 16 or 20 bits wide. The host offers either a data word or a control word. When it offers neither, the block sends a fill frame whose data field is all ones. A fill-type input chooses between two kinds of fill. The second kind has two variants, picked by the sign of the running line disparity.

To keep the long-term line balance near zero, the encoder keeps a signed running sum of (ones minus zeros) over every bit it has sent. It complements a whole frame whenever that frame's own disparity would push the sum further from zero. The frame word is registered and is followed by a serializer that is not part of this block. An invert indicator and a frame-valid strobe go with each frame.

Top module: `frame_encoder`

## Requirements
- R1: While `rstN` is low at a clock edge, the frame after that edge is fill type 0 sent true: control 0011, flag 0, active data bits all ones. In the same frame `invOut` is 0 and `frameValid` is 0. The running sum and the flag alternation both return to zero.
- R2: Each frame is registered and appears one clock after its inputs are sampled. `frameValid` is 1 for every frame whose clock edge saw `rstN` high.
- R3: Frame layout is control field in `frameOut[24:21]`, flag in `frameOut[20]` and data in `frameOut[19:0]`. With `wide20` low, only `frameOut[15:0]` carry data and `frameOut[19:16]` are always 0. The active width is 21 bits with `wide20` low and 25 bits with `wide20` high.
- R4: When `dataAvail` is 1, the frame is a data frame with control 0101 and `wordIn` in the data field. `dataAvail` wins over `ctrlAvail`.
- R5: When only `ctrlAvail` is 1, the frame is a control frame with control 0110 and `wordIn` in the data field.
- R6: When neither word type is offered and `fillSel` is 0, the frame is fill type 0: control 0011, flag 0, data all ones.
- R7: With `userFlagMode` low, data frames carry flag 0, 1, 0, 1, … starting at 0 after reset. Only data frames advance this sequence. Control and fill frames carry flag 0.
- R8: With `userFlagMode` high, data and control frames carry `flagIn` as their flag bit. The alternation sequence does not advance.
- R9: Data, control and fill type 0 frames are complemented on all active bits, with `invOut` high, exactly when the running sum is nonzero and the frame's true disparity has the same sign as the sum.
- R10: The running sum adds the disparity (ones minus zeros over the active bits) of each frame as it is sent.
- R11: A fill type 1 frame (neither word offered, `fillSel` 1) takes one of two forms. When the running sum is at least 0, it uses control 1011 and is always sent complemented. When the sum is negative, it uses control 0111 and is always sent true.
- R12: The running sum stays within plus or minus twice the full frame width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Synchronous reset, active low |
| wide20 | input | 1 | 1 selects the 20-bit data field, 0 selects 16 bits |
| userFlagMode | input | 1 | 1 makes the flag a user data bit |
| dataAvail | input | 1 | The offered word is data |
| ctrlAvail | input | 1 | The offered word is a control word |
| fillSel | input | 1 | Fill kind sent when idle (0 or 1) |
| wordIn | input | 20 | Offered word |
| flagIn | input | 1 | User flag bit |
| frameOut | output | 25 | Encoded frame as sent |
| invOut | output | 1 | Frame was sent complemented |
| frameValid | output | 1 | Frame strobe |

## Verification
The hardest corner to reach is fill type 1 with a negative running sum, together with the decisions taken at a sum of exactly zero. Random words rarely land the sum on a chosen sign at the moment the host goes idle. The stimulus therefore starts from reset at sum zero and sends an all-zeros data word, which is sent true and drives the sum negative. Fill type 1 then follows, and an all-ones data word repeats the pattern on the positive side. A long pseudo-random run that mixes widths, flag modes and frame kinds then compares every frame against a bench model of the running sum.

// File: rtl/frame_enc_pkg.sv
package frame_enc_pkg;

  localparam int CTRL_W = 4;

  localparam logic [CTRL_W-1:0] CODE_DATA  = 4'b0101;
  localparam logic [CTRL_W-1:0] CODE_CTRL  = 4'b0110;
  localparam logic [CTRL_W-1:0] CODE_FILL0 = 4'b0011;
  localparam logic [CTRL_W-1:0] CODE_FILL1A = 4'b1011;
  localparam logic [CTRL_W-1:0] CODE_FILL1B = 4'b0111;

  typedef enum logic [2:0] {
    KIND_DATA,
    KIND_CTRL,
    KIND_FILL0,
    KIND_FILL1A,
    KIND_FILL1B
  } frameKind_e;

  typedef enum logic [1:0] {
    INV_RULE,
    INV_FORCE,
    INV_NEVER
  } invMode_e;

  typedef struct packed {
    frameKind_e kind;
    invMode_e   invMode;
    logic       flagBit;
    logic       loadReset;
  } encStrobe_t;

endpackage

// File: rtl/frame_enc_ctrl.sv
module frame_enc_ctrl
  import frame_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       userFlagMode,
  input  logic       dataAvail,
  input  logic       ctrlAvail,
  input  logic       fillSel,
  input  logic       flagIn,
  input  logic       sumNeg,
  output encStrobe_t strobe
);

  logic flagPhase;

  // Alternating flag: advances only on data frames outside user-flag mode (R7)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagPhase <= 1'b0;
    end else if (dataAvail && !userFlagMode) begin
      flagPhase <= ~flagPhase;
    end
  end

  always_comb begin
    strobe.kind      = KIND_FILL0;
    strobe.invMode   = INV_RULE;
    strobe.flagBit   = 1'b0;
    strobe.loadReset = 1'b0;
    if (!rstN) begin
      strobe.loadReset = 1'b1;
    end else if (dataAvail) begin
      strobe.kind    = KIND_DATA;
      strobe.flagBit = userFlagMode ? flagIn : flagPhase;
    end else if (ctrlAvail) begin
      strobe.kind    = KIND_CTRL;
      strobe.flagBit = userFlagMode ? flagIn : 1'b0;
    end else if (fillSel) begin
      if (sumNeg) begin
        strobe.kind    = KIND_FILL1B;
        strobe.invMode = INV_NEVER;
      end else begin
        strobe.kind    = KIND_FILL1A;
        strobe.invMode = INV_FORCE;
      end
    end
  end

  a_r7_flag_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (dataAvail && !userFlagMode) |=> (flagPhase != $past(flagPhase)));

  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!dataAvail || userFlagMode) |=> $stable(flagPhase));

endmodule

// File: rtl/frame_enc_datapath.sv
module frame_enc_datapath
  import frame_enc_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int NARROW_W = 16,
  parameter int SUM_W    = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wide,
  input  encStrobe_t                 strobe,
  input  logic [DATA_W-1:0]          wordIn,
  output logic [CTRL_W+DATA_W:0]     frameOut,
  output logic                       invOut,
  output logic                       frameValid,
  output logic                       sumNeg
);

  localparam int FRAME_W  = CTRL_W + 1 + DATA_W;
  localparam int NARROW_FRAME_W = CTRL_W + 1 + NARROW_W;
  localparam int ONES_W   = $clog2(FRAME_W + 1);
  localparam int BOUND    = 2 * FRAME_W;
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0]        dataMask;
  logic [CTRL_W-1:0]        ctrlCode;
  logic [DATA_W-1:0]        dataField;
  logic                     flagField;
  logic [FRAME_W-1:0]       trueFrame;
  logic [FRAME_W-1:0]       invMask;
  logic [FRAME_W-1:0]       sentFrame;
  logic [ONES_W-1:0]        onesCount;
  logic signed [SUM_W-1:0]  activeCount;
  logic signed [SUM_W-1:0]  trueDisp;
  logic signed [SUM_W-1:0]  sentDisp;
  logic signed [SUM_W-1:0]  runSum;
  logic                     sumZero;
  logic                     doInv;

  assign dataMask    = wide ? {DATA_W{1'b1}} : NARROW_MASK;
  assign activeCount = wide ? SUM_W'(FRAME_W) : SUM_W'(NARROW_FRAME_W);

  always_comb begin
    unique case (strobe.kind)
      KIND_DATA:   ctrlCode = CODE_DATA;
      KIND_CTRL:   ctrlCode = CODE_CTRL;
      KIND_FILL1A: ctrlCode = CODE_FILL1A;
      KIND_FILL1B: ctrlCode = CODE_FILL1B;
      default:     ctrlCode = CODE_FILL0;
    endcase
  end

  always_comb begin
    if (strobe.kind == KIND_DATA || strobe.kind == KIND_CTRL) begin
      dataField = wordIn & dataMask;
      flagField = strobe.flagBit;
    end else begin
      dataField = dataMask;
      flagField = 1'b0;
    end
  end

  assign trueFrame = {ctrlCode, flagField, dataField};
  assign invMask   = {{(CTRL_W+1){1'b1}}, dataMask};

  always_comb begin
    onesCount = '0;
    for (int i = 0; i < FRAME_W; i++) begin
      onesCount = onesCount + ONES_W'(trueFrame[i]);
    end
  end

  // Active widths are odd, so a true disparity is never zero
  assign trueDisp = (SUM_W'(onesCount) <<< 1) - activeCount;
  assign sumZero  = (runSum == '0);
  assign sumNeg   = runSum[SUM_W-1];

  always_comb begin
    doInv = 1'b0;
    if (!strobe.loadReset) begin
      unique case (strobe.invMode)
        INV_FORCE: doInv = 1'b1;
        INV_NEVER: doInv = 1'b0;
        default:   doInv = !sumZero && (trueDisp[SUM_W-1] == runSum[SUM_W-1]);
      endcase
    end
  end

  assign sentFrame = doInv ? (trueFrame ^ invMask) : trueFrame;
  assign sentDisp  = doInv ? -trueDisp : trueDisp;

  always_ff @(posedge clk) begin
    frameOut <= sentFrame;
    if (!rstN) begin
      runSum     <= '0;
      invOut     <= 1'b0;
      frameValid <= 1'b0;
    end else begin
      runSum     <= runSum + sentDisp;
      invOut     <= doInv;
      frameValid <= 1'b1;
    end
  end

  a_r1_reset_frame: assert property (@(posedge clk)
    !rstN |=> (!frameValid && !invOut &&
               frameOut[FRAME_W-1 -: CTRL_W] == CODE_FILL0 && !frameOut[DATA_W]));

  a_r2_valid_after_run: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> frameValid);

  a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    !wide |=> (frameOut[DATA_W-1:NARROW_W] == '0));

  a_r9_zero_sum_true: assert property (@(posedge clk) disable iff (!rstN)
    (sumZero && strobe.invMode == INV_RULE) |=> !invOut);

  a_r11_fill1_forced: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.invMode == INV_FORCE) |=> invOut);

  a_r12_sum_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (runSum <= BOUND) && (runSum >= -BOUND));

endmodule

// File: rtl/frame_encoder.sv
module frame_encoder
  import frame_enc_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int NARROW_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wide20,
  input  logic                   userFlagMode,
  input  logic                   dataAvail,
  input  logic                   ctrlAvail,
  input  logic                   fillSel,
  input  logic [DATA_W-1:0]      wordIn,
  input  logic                   flagIn,
  output logic [CTRL_W+DATA_W:0] frameOut,
  output logic                   invOut,
  output logic                   frameValid
);

  localparam int FRAME_W = CTRL_W + 1 + DATA_W;
  localparam int SUM_W   = $clog2(4 * FRAME_W + 1) + 2;

  encStrobe_t strobe;
  logic       sumNeg;

  frame_enc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .userFlagMode (userFlagMode),
    .dataAvail    (dataAvail),
    .ctrlAvail    (ctrlAvail),
    .fillSel      (fillSel),
    .flagIn       (flagIn),
    .sumNeg       (sumNeg),
    .strobe       (strobe)
  );

  frame_enc_datapath #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .SUM_W    (SUM_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wide       (wide20),
    .strobe     (strobe),
    .wordIn     (wordIn),
    .frameOut   (frameOut),
    .invOut     (invOut),
    .frameValid (frameValid),
    .sumNeg     (sumNeg)
  );

endmodule

// File: tb/frame_encoder_bench.sv
`timescale 1ns/1ps
module frame_encoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wide20 = 1'b0;
  logic        userFlagMode = 1'b0;
  logic        dataAvail = 1'b0;
  logic        ctrlAvail = 1'b0;
  logic        fillSel = 1'b0;
  logic [19:0] wordIn = '0;
  logic        flagIn = 1'b0;
  logic [24:0] frameOut;
  logic        invOut;
  logic        frameValid;

  always #4 clk = ~clk;

  frame_encoder u_frame_encoder (
    .clk(clk), .rstN(rstN), .wide20(wide20), .userFlagMode(userFlagMode),
    .dataAvail(dataAvail), .ctrlAvail(ctrlAvail), .fillSel(fillSel),
    .wordIn(wordIn), .flagIn(flagIn),
    .frameOut(frameOut), .invOut(invOut), .frameValid(frameValid)
  );

  typedef struct {
    logic [24:0] frame;
    logic        inv;
    logic        valid;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  int mSum = 0;
  bit mTog = 1'b0;
  bit finished = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic drive(input bit rst, input bit wide, input bit ufm,
                       input bit dAv, input bit cAv, input bit fsel,
                       input logic [19:0] w, input bit flg, input string tag);
    expItem_t it;
    logic [3:0]  code;
    logic [19:0] mask;
    logic [19:0] dat;
    logic        flag;
    logic [24:0] t;
    int          active;
    int          disp;
    int          mode; // 0 rule, 1 force, 2 never
    bit          inv;
    @(negedge clk);
    rstN = rst; wide20 = wide; userFlagMode = ufm; dataAvail = dAv;
    ctrlAvail = cAv; fillSel = fsel; wordIn = w; flagIn = flg;
    mask   = wide ? 20'hFFFFF : 20'h0FFFF;
    active = wide ? 25 : 21;
    mode   = 0;
    flag   = 1'b0;
    dat    = mask;
    if (!rst) begin
      code = 4'b0011;
    end else if (dAv) begin
      code = 4'b0101; dat = w & mask;
      flag = ufm ? flg : mTog;
    end else if (cAv) begin
      code = 4'b0110; dat = w & mask;
      flag = ufm ? flg : 1'b0;
    end else if (fsel) begin
      if (mSum >= 0) begin code = 4'b1011; mode = 1; end
      else begin code = 4'b0111; mode = 2; end
    end else begin
      code = 4'b0011;
    end
    t = {code, flag, dat};
    disp = 2 * $countones(t) - active;
    if (!rst) inv = 1'b0;
    else if (mode == 1) inv = 1'b1;
    else if (mode == 2) inv = 1'b0;
    else inv = (mSum != 0) && ((disp > 0) == (mSum > 0));
    if (inv) begin
      t = t ^ {5'h1F, mask};
      disp = -disp;
    end
    if (!rst) begin
      mSum = 0; mTog = 1'b0;
    end else begin
      mSum = mSum + disp;
      if (dAv && !ufm) mTog = ~mTog;
    end
    it.frame = t; it.inv = inv; it.valid = rst; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares each registered frame against the scoreboard head
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (frameOut !== e.frame || invOut !== e.inv || frameValid !== e.valid) begin
          errors++;
          $display("FAIL %s: frame=%h inv=%b valid=%b expected frame=%h inv=%b valid=%b",
                   e.tag, frameOut, invOut, frameValid, e.frame, e.inv, e.valid);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset frames in both widths
    drive(0, 0, 0, 0, 0, 0, 20'h0, 0, "R1");
    drive(0, 0, 0, 1, 0, 0, 20'hABCDE, 1, "R1");
    drive(0, 1, 0, 0, 0, 1, 20'h0, 0, "R1");
    drive(0, 0, 0, 0, 0, 0, 20'h0, 0, "R1");
    // R9: zero sum sends an all-zeros data word true, sum goes negative
    drive(1, 0, 0, 1, 0, 0, 20'h00000, 0, "R9 R2");
    // R11: fill type 1 with negative sum, variant sent true
    drive(1, 0, 0, 0, 0, 1, 20'h0, 0, "R11");
    // R7: second data frame carries flag 1; all-ones data from zero sum
    drive(1, 0, 0, 1, 0, 0, 20'hFFFFF, 0, "R7 R3");
    // R11: fill type 1 with positive sum, forced complement
    drive(1, 0, 0, 0, 0, 1, 20'h0, 0, "R11");
    // R6: fill type 0
    drive(1, 0, 0, 0, 0, 0, 20'h0, 0, "R6");
    drive(1, 0, 0, 0, 0, 0, 20'h0, 0, "R6 R9");
    // R4: data has priority over control
    drive(1, 0, 0, 1, 1, 0, 20'h1234, 0, "R4");
    // R5: control frames, flag 0, alternation held
    drive(1, 0, 0, 0, 1, 0, 20'h0F0F, 1, "R5");
    drive(1, 0, 0, 0, 1, 1, 20'hFFF0, 0, "R5");
    drive(1, 0, 0, 1, 0, 0, 20'h5A5A, 0, "R7");
    drive(1, 0, 0, 1, 0, 0, 20'hA5A5, 0, "R7");
    // R8: user flag mode on data and control
    drive(1, 0, 1, 1, 0, 0, 20'h0001, 1, "R8");
    drive(1, 0, 1, 1, 0, 0, 20'h0002, 1, "R8");
    drive(1, 0, 1, 0, 1, 0, 20'h0003, 1, "R8");
    drive(1, 0, 0, 1, 0, 0, 20'h0004, 0, "R8 R7");
    // R3: 20-bit frames, narrow mode hides upper bits of wordIn
    drive(1, 1, 0, 1, 0, 0, 20'hF0000, 0, "R3");
    drive(1, 1, 0, 0, 0, 0, 20'h0, 0, "R3 R6");
    drive(1, 0, 0, 1, 0, 0, 20'hFFFFF, 0, "R3");
    drive(1, 1, 0, 0, 0, 1, 20'h0, 0, "R3 R11");
    // R10 R12: long mixed run
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(1, lfsr[3], lfsr[5] & lfsr[6], lfsr[7] & lfsr[8], lfsr[9],
            lfsr[10], lfsr[31:12], lfsr[11], "R10 R12");
    end
    // R1: reset mid-run, then R7 flag restarts at 0
    drive(0, 1, 0, 1, 0, 0, 20'h0, 0, "R1");
    drive(1, 1, 0, 1, 0, 0, 20'h33333, 0, "R7 R1");
    drive(1, 1, 0, 1, 0, 0, 20'h33333, 0, "R7");
    @(negedge clk);
    dataAvail = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule